// File: doc/BRIEF.md
# Sliding-Window Reuse Stream Buffer

This block sits between a wide memory read stream and an unrolled, pipelined datapath that evaluates a three-point window function for every output index. Each input beat carries four consecutive 32-bit array elements. Each array element is read from memory exactly once. The block keeps the elements that overlap between neighbouring windows and presents four complete, consecutive windows per output transfer. The downstream datapath therefore receives more element bandwidth than the memory stream alone delivers.

A start pulse loads the number of outputs N for the next stream and clears any carried data and counters. The block then accepts exactly the beats that hold elements 0 through N+1. It emits ceil(N/4) window groups and flags the final group. When N is not a multiple of four, it marks the unused lanes of the final group through a lane-valid mask. Both sides use valid/ready handshakes. When the output side stalls and internal storage is full, the input ready signal drops so that memory reads pause.

Top module: `win_reuse_buf`

## Requirements
- R1: In an output group g, window lane j (0..3) holds elements e[4g+j], e[4g+j+1] and e[4g+j+2]. Element e[4g+j+t] sits at out_data bits [(3j+t)*32 +: 32], so the lowest index of each window is in its lowest 32 bits.
- R2: Input beat b carries elements e[4b..4b+3]. Element e[4b+m] is at in_data bits [32m +: 32].
- R3: For a count N of at least 1, exactly ceil((N+2)/4) beats are accepted per stream. Beats offered beyond that are never accepted.
- R4: A stream produces exactly ceil(N/4) groups. Every group except the last has out_lane_mask = 4'b1111 and out_last = 0. The final group has out_last = 1.
- R5: In group g, out_lane_mask bit j is 1 exactly when 4g+j < N. The mask is therefore always a nonempty run of ones starting at bit 0.
- R6: A group is presented only once all elements of its valid windows have been accepted. For N of at least 3, no group appears while only the first beat has been accepted.
- R7: While out_valid is high and out_ready is low, out_data, out_lane_mask and out_last hold steady. If the held beat and the output register are both occupied during such a stall, in_ready is low.
- R8: A start pulse discards any carried elements, any pending group and all counts, then loads the new N. A stream started after an interrupted one delivers windows of the new stream only. N = 0 accepts no beat and produces no group.
- R9: After the final group is transferred, out_valid and in_ready stay low until the next start pulse.
- R10: After reset, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a new stream |
| total_n | input | 16 | Output count N, sampled when start is high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_data | input | 128 | Four packed elements, lowest index in the low bits |
| out_valid | output | 1 | Window group present |
| out_ready | input | 1 | Datapath accepts the group this cycle |
| out_data | output | 384 | Four packed windows of three elements |
| out_lane_mask | output | 4 | Valid windows in the group, bit j for lane j |
| out_last | output | 1 | Final group of the stream |

## Verification
The assertions assume that start is not raised while a beat or group handshake is in flight from an earlier stream it should complete. They also assume that total_n is stable during the start cycle. The bench raises start only between streams, or deliberately mid-stream to test discard, and keeps in_valid asserted with the same data until a beat is accepted. No assertion constrains out_ready, so the bench drives it freely at random, including long stalls. The input side is throttled at several rates, so the stall blocking and the output hold rules are exercised against arbitrary sink behaviour.

// File: rtl/win_reuse_pkg.sv
package win_reuse_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;

  // Beats needed to deliver elements 0 .. n+taps-2 when each beat holds lanes elements.
  function automatic int unsigned beats_for(int unsigned n, int unsigned lanes,
                                            int unsigned taps);
    if (n == 0) return 0;
    return (n + taps - 1 + lanes - 1) / lanes;
  endfunction

  // Window groups needed for n outputs, lanes windows per group.
  function automatic int unsigned groups_for(int unsigned n, int unsigned lanes);
    return (n + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/win_seq_ctrl.sv
module win_seq_ctrl
  import win_reuse_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAPS  = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_n,
  input  logic             in_valid,
  input  logic             hold_vld,
  input  logic             out_valid,
  input  logic             out_ready,
  input  logic             out_last,
  output logic             in_ready,
  output logic             ev_load,
  output logic             ev_pair,
  output logic             ev_flush,
  output logic             hold_keep,
  output logic [LANES-1:0] grp_mask,
  output logic             grp_last
);
  localparam int IW = CNT_W + $clog2(LANES) + 2;

  run_st_t          st;
  logic [CNT_W-1:0] n_tot, beats_tot, groups_tot;
  logic [CNT_W-1:0] beats_in, groups_fm;
  logic             run, out_free, beat_left, grp_left, can_form, in_fire, ev_grp;
  logic [IW-1:0]    base;

  assign run       = (st == ST_RUN);
  assign out_free  = !out_valid || out_ready;
  assign beat_left = (beats_in != beats_tot);
  assign grp_left  = (groups_fm != groups_tot);
  assign can_form  = run && out_free && grp_left && hold_vld;

  assign ev_pair   = can_form && beat_left && in_valid;
  assign ev_flush  = can_form && !beat_left;
  assign ev_load   = run && !hold_vld && beat_left && in_valid;
  assign ev_grp    = ev_pair || ev_flush;
  assign in_ready  = run && beat_left && (!hold_vld || (out_free && grp_left));
  assign in_fire   = in_valid && in_ready;

  assign hold_keep = ((groups_fm + 1'b1) != groups_tot);
  assign grp_last  = ((groups_fm + 1'b1) == groups_tot);
  assign base      = IW'(groups_fm) * IW'(LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign grp_mask[j] = (base + IW'(j)) < IW'(n_tot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      n_tot      <= '0;
      beats_tot  <= '0;
      groups_tot <= '0;
      beats_in   <= '0;
      groups_fm  <= '0;
    end else if (start) begin
      st         <= ST_RUN;
      n_tot      <= total_n;
      beats_tot  <= CNT_W'(beats_for(32'(total_n), LANES, TAPS));
      groups_tot <= CNT_W'(groups_for(32'(total_n), LANES));
      beats_in   <= '0;
      groups_fm  <= '0;
    end else begin
      if (in_fire) beats_in  <= beats_in + 1'b1;
      if (ev_grp)  groups_fm <= groups_fm + 1'b1;
      if (run && out_valid && out_ready && out_last) st <= ST_IDLE;
    end
  end

  // A stalled output with a held beat leaves no room for another beat
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && hold_vld) |-> !in_ready); // R7

  // A flush group is formed only after the whole beat budget was taken
  AST_FLUSH_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |-> !in_fire); // R3

endmodule

// File: rtl/win_assembler.sv
module win_assembler #(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4,
  parameter int TAPS   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        ev_load,
  input  logic                        ev_pair,
  input  logic                        ev_flush,
  input  logic                        hold_keep,
  input  logic [LANES*ELEM_W-1:0]     in_data,
  output logic                        hold_vld,
  output logic [LANES*TAPS*ELEM_W-1:0] grp_data
);
  localparam int CARRY  = TAPS - 1;
  localparam int EXT_N  = LANES + CARRY;
  localparam int BEAT_W = LANES * ELEM_W;

  logic [BEAT_W-1:0]       hold;
  logic [CARRY*ELEM_W-1:0] head;
  logic [EXT_N*ELEM_W-1:0] ext;

  // Leading elements of the incoming beat complete the held beat's windows;
  // a flush group has no incoming beat and fills the spare tail with zero.
  assign head = ev_pair ? in_data[CARRY*ELEM_W-1:0] : '0;
  assign ext  = {head, hold};

  for (genvar j = 0; j < LANES; j++) begin : g_win
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign grp_data[(j*TAPS+t)*ELEM_W +: ELEM_W] = ext[(j+t)*ELEM_W +: ELEM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold     <= '0;
    end else if (clr) begin
      hold_vld <= 1'b0;
      hold     <= '0;
    end else if (ev_load) begin
      hold_vld <= 1'b1;
      hold     <= in_data;
    end else if (ev_pair) begin
      hold_vld <= hold_keep;
      hold     <= in_data;
    end else if (ev_flush) begin
      hold_vld <= 1'b0;
    end
  end

  // Every group is built on a beat already held
  AST_GROUP_HAS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pair || ev_flush) |-> hold_vld); // R6

  // Loading an empty buffer and pairing a new beat never coincide
  AST_ONE_BEAT_USE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_load && (ev_pair || ev_flush))); // R3

endmodule

// File: rtl/win_out_stage.sv
module win_out_stage #(
  parameter int W     = 384,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [W-1:0]     load_data,
  input  logic [LANES-1:0] load_mask,
  input  logic             load_last,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [LANES-1:0] out_mask,
  output logic             out_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mask  <= '0;
      out_last  <= 1'b0;
    end else if (clr) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_mask  <= load_mask;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=>
      (out_valid && $stable(out_data) && $stable(out_mask) && $stable(out_last))); // R7

endmodule

// File: rtl/win_reuse_buf.sv
module win_reuse_buf #(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4,
  parameter int TAPS   = 3,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [CNT_W-1:0]              total_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*ELEM_W-1:0]       in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANES*TAPS*ELEM_W-1:0]  out_data,
  output logic [LANES-1:0]              out_lane_mask,
  output logic                          out_last
);
  localparam int GRP_W = LANES * TAPS * ELEM_W;

  logic             ev_load, ev_pair, ev_flush, ev_grp, hold_keep, hold_vld, grp_last;
  logic [LANES-1:0] grp_mask;
  logic [GRP_W-1:0] grp_data;

  assign ev_grp = ev_pair || ev_flush;

  win_seq_ctrl #(.LANES(LANES), .TAPS(TAPS), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .total_n   (total_n),
    .in_valid  (in_valid),
    .hold_vld  (hold_vld),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .in_ready  (in_ready),
    .ev_load   (ev_load),
    .ev_pair   (ev_pair),
    .ev_flush  (ev_flush),
    .hold_keep (hold_keep),
    .grp_mask  (grp_mask),
    .grp_last  (grp_last)
  );

  win_assembler #(.ELEM_W(ELEM_W), .LANES(LANES), .TAPS(TAPS)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .ev_load   (ev_load),
    .ev_pair   (ev_pair),
    .ev_flush  (ev_flush),
    .hold_keep (hold_keep),
    .in_data   (in_data),
    .hold_vld  (hold_vld),
    .grp_data  (grp_data)
  );

  win_out_stage #(.W(GRP_W), .LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .load      (ev_grp),
    .load_data (grp_data),
    .load_mask (grp_mask),
    .load_last (grp_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_mask  (out_lane_mask),
    .out_last  (out_last)
  );

  // A paired group always consumes the beat presented with it
  AST_PAIR_TAKES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair |-> (in_valid && in_ready)); // R3

  AST_STEADY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (&out_lane_mask)); // R4

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_mask[0] &&
                   ((LANES'(out_lane_mask + 1'b1) & out_lane_mask) == '0))); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !start) |=> (!out_valid && !in_ready)); // R9

endmodule

// File: tb/test_win_reuse_buf.sv
module test_win_reuse_buf;
  localparam int EW = 32;
  localparam int LN = 4;
  localparam int TP = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [15:0]      total_n = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [LN*EW-1:0] in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [LN*TP*EW-1:0] out_data;
  logic [LN-1:0]    out_lane_mask;
  logic             out_last;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  win_reuse_buf i_win_reuse_buf (
    .clk(clk), .rst_n(rst_n), .start(start), .total_n(total_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lane_mask(out_lane_mask), .out_last(out_last)
  );

  function automatic logic [31:0] elem(int i, logic [31:0] salt);
    return (32'(i) * 32'h9E3779B1) ^ salt;
  endfunction

  function automatic logic [LN*EW-1:0] beat_word(int b, logic [31:0] salt);
    logic [LN*EW-1:0] w;
    for (int m = 0; m < LN; m++) w[m*EW +: EW] = elem(b*LN + m, salt);
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(int n);
    @(posedge clk); #1;
    start = 1'b1; total_n = 16'(n); in_valid = 1'b0; out_ready = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // Full stream with throttled input and random sink; checks windows, masks,
  // group and beat counts, then the idle state after the last group.
  task automatic run_stream(int n, logic [31:0] salt, int in_rate, int out_rate, string tag);
    int need_b = (n + 2 + 3) / 4;
    int need_g = (n + 3) / 4;
    int beat = 0, grp = 0, cyc = 0;
    bit fired = 0, done = 0, data_ok = 1, mask_ok = 1, last_ok = 1;
    pulse_start(n);
    while (!done && cyc < 6000) begin
      @(posedge clk); #1;
      cyc++;
      if (fired) begin in_valid = 1'b0; fired = 0; end
      if (!in_valid && beat < need_b + 2 && $urandom_range(0, 99) < in_rate) begin
        in_valid = 1'b1;
        in_data  = beat_word(beat, salt);
      end
      out_ready = ($urandom_range(0, 99) < out_rate);
      @(negedge clk);
      if (in_valid && in_ready) begin beat++; fired = 1; end
      if (out_valid && out_ready) begin
        for (int j = 0; j < LN; j++) begin
          bit lv = (grp*LN + j) < n;
          if (out_lane_mask[j] != lv) mask_ok = 0;
          if (lv)
            for (int t = 0; t < TP; t++)
              if (out_data[(j*TP+t)*EW +: EW] !== elem(grp*LN + j + t, salt)) data_ok = 0;
        end
        if (out_last != (grp == need_g - 1)) last_ok = 0;
        grp++;
        if (out_last) done = 1;
      end
    end
    chk(data_ok, "R1", {tag, " window contents (R2 beat packing)"}, data_ok, 1);
    chk(mask_ok, "R5", {tag, " lane mask"}, mask_ok, 1);
    chk(last_ok && grp == need_g, "R4", {tag, " group count/last"}, grp, need_g);
    chk(beat == need_b, "R3", {tag, " beats accepted"}, beat, need_b);
    // keep offering a beat after completion: it must not be taken (R3, R9)
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = beat_word(beat, salt); out_ready = 1'b1;
    begin
      bit quiet = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (in_ready || out_valid) quiet = 0;
      end
      chk(quiet, "R9", {tag, " idle after final group"}, quiet, 1);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk(!out_valid, "R10", "out_valid after reset", out_valid, 0);
    chk(!in_ready, "R10", "in_ready after reset", in_ready, 0);
  endtask

  // R6: one beat alone must not yield a group; R8: restart discards it
  task automatic test_first_beat_then_restart;
    int taken = 0;
    bit seen = 0;
    pulse_start(9);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = beat_word(0, 32'h1111_0000); out_ready = 1'b1;
    @(negedge clk);
    if (in_ready) taken++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    chk(taken == 1, "R6", "first beat accepted", taken, 1);
    chk(!seen, "R6", "no group from first beat alone", seen, 0);
    chk(in_ready, "R6", "ready for second beat", in_ready, 1);
    run_stream(5, 32'h2222_5555, 100, 100, "R8 restart");
  endtask

  // R7: output stall with held beat blocks input; presented group is stable
  task automatic test_backpressure;
    int taken = 0;
    logic [LN*TP*EW-1:0] snap;
    bit stable = 1, g0_ok = 1;
    pulse_start(16);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = beat_word(taken, 32'h3333_0000); out_ready = 1'b0;
      @(negedge clk);
      if (in_valid && in_ready) taken++;
      if (k == 4) snap = out_data;
      if (k > 4 && out_data !== snap) stable = 0;
    end
    chk(taken == 2, "R7", "beats taken while output stalled", taken, 2);
    chk(!in_ready, "R7", "in_ready low during stall", in_ready, 0);
    chk(out_valid && stable, "R7", "stalled group held steady", stable, 1);
    for (int j = 0; j < LN; j++)
      for (int t = 0; t < TP; t++)
        if (out_data[(j*TP+t)*EW +: EW] !== elem(j + t, 32'h3333_0000)) g0_ok = 0;
    chk(g0_ok && out_lane_mask == 4'hF, "R1", "first group under stall", out_lane_mask, 4'hF);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // R8: zero count takes nothing and emits nothing
  task automatic test_zero;
    bit any = 0;
    pulse_start(0);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = beat_word(0, 32'h4444_0000); out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (in_ready || out_valid) any = 1;
    end
    chk(!any, "R8", "zero count idle", any, 0);
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    run_stream(8,  32'hA000_0001, 100, 100, "N8 full rate");
    run_stream(1,  32'hA000_0002, 70,  60,  "N1 flush");
    run_stream(2,  32'hA000_0003, 50,  50,  "N2 flush");
    run_stream(3,  32'hA000_0004, 60,  40,  "N3");
    run_stream(5,  32'hA000_0005, 40,  80,  "N5 flush");
    run_stream(13, 32'hA000_0006, 80,  30,  "N13");
    run_stream(30, 32'hA000_0007, 35,  65,  "N30");
    run_stream(64, 32'hA000_0008, 90,  90,  "N64");
    test_first_beat_then_restart();
    test_backpressure();
    test_zero();
    run_stream(7,  32'hA000_0009, 55,  45,  "N7 after zero");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule